// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small set of hardware semaphore tokens that two independent requesters, a left port and a right port, share. Each token is a two-sided flag. A port asks for a token by writing a 0 to it. It learns whether it holds the token by reading: a 0 means it owns the token, and a 1 means it does not. It gives the token back by writing a 1. The unit sits beside a shared memory. A port reaches semaphore space only while its semaphore select is high and its memory enable is low.

Contention is settled inside the block, so at most one port ever holds a given token. If both ports ask for the same free token in the same clock cycle, the left port gets it. A request from the port that does not own the token is not dropped. It is remembered, and when the owner releases the token, ownership passes straight to the waiting port. The design is fully synchronous on one clock. The read bit is a combinational view of the registered token state, so the result of a write can be read back in the cycle after the write edge.

Top module: `sem_dual_token`

## Requirements
- R1: A port reaches semaphore space only when its select is 1 and its memory enable is 0. Outside that condition its writes change no token, and its read bit is 1.
- R2: After reset every token is free and no request is pending, so every read from either port returns 1.
- R3: A write with data bit 0 to a free token gives that token to the writing port. From the next cycle the owner reads 0 and the other port reads 1.
- R4: When both ports write 0 to the same free token in the same cycle, the left port becomes the owner and the right port's request is recorded as pending.
- R5: A write of 0 from the port that does not own a held token leaves the ownership unchanged, and that port keeps reading 1.
- R6: When the owner writes 1 and no request from the other port is pending or arriving, the token becomes free and both ports read 1.
- R7: When the owner writes 1 while the other port has a pending request, or writes 0 in that same cycle, ownership passes to the other port, which reads 0 from the next cycle.
- R8: A write of 1 from the port that does not own the token withdraws its pending request. A later release by the owner then frees the token.
- R9: There are 8 independent tokens. Bits [2:0] of a port's address select the token, and the higher address bits are ignored.
- R10: A write of 0 from the current owner has no effect: the owner keeps the token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_sem_sel | input | 1 | Left port semaphore select |
| l_mem_en | input | 1 | Left port memory enable; blocks semaphore access when 1 |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | 15 | Left port address; low bits pick the token |
| l_wbit | input | 1 | Left port write data bit (0 request, 1 release) |
| l_rbit | output | 1 | Left port read bit (0 = left owns the selected token) |
| r_sem_sel | input | 1 | Right port semaphore select |
| r_mem_en | input | 1 | Right port memory enable; blocks semaphore access when 1 |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | 15 | Right port address; low bits pick the token |
| r_wbit | input | 1 | Right port write data bit (0 request, 1 release) |
| r_rbit | output | 1 | Right port read bit (0 = right owns the selected token) |

## Verification
The assertions check on every cycle:
- Two ports reading the same token never both see 0.
- The owner side never carries a pending request, and a free token holds no pending request at all.
- A grant, a tie or a release moves the owner state as the rules require.
- A port that is not in semaphore space produces no request.

Only the bench scenarios can show the following:
- The read values each port sees after a sequence of writes.
- That blocked writes and writes to upper address bits leave the tokens untouched.
- The full request, defer, hand-over and withdraw sequences across several cycles.

// File: rtl/sem_pkg.sv
// Shared types for the dual-port semaphore unit.
package sem_pkg;
    // Owner state of one token.
    typedef enum logic [1:0] {
        TOK_FREE  = 2'b00,
        TOK_LEFT  = 2'b01,
        TOK_RIGHT = 2'b10
    } tok_owner_t;
endpackage

// File: rtl/sem_port_decode.sv
// Per-port access decoder.
// Turns one port's select, memory enable, write strobe, address and data
// bit into one-hot request and release vectors, one bit per token.
// Assumes NUM_FLAGS is a power of two; the address bits above the slot
// field are ignored.
module sem_port_decode #(
    parameter int ADDR_W    = 15,
    parameter int NUM_FLAGS = 8,
    localparam int SLOT_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sem_sel,
    input  logic                 mem_en,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic                 acc,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_FLAGS-1:0] req,
    output logic [NUM_FLAGS-1:0] rel
);
    // Semaphore space is reached only with select high and memory enable low.
    assign acc  = sem_sel & ~mem_en;
    assign slot = addr[SLOT_W-1:0];

    // One request/release strobe per token slot.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_slot
        logic hit;
        assign hit    = acc & wr & (slot == SLOT_W'(g));
        assign req[g] = hit & ~wbit;
        assign rel[g] = hit &  wbit;
    end

    // R1: no strobe leaves a port that is outside semaphore space.
    p_no_strobe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> (req == '0 && rel == '0));

    // R9: a single write addresses at most one token.
    p_single_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req | rel));
endmodule

// File: rtl/sem_flag.sv
// One two-sided semaphore token.
// Tracks the owner and one pending request per side. Left wins a tie on
// a free token. A non-owner request is deferred until the owner releases.
// Assumes at most one of req/rel per side in a cycle (the decoder ensures this).
module sem_flag
    import sem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_l,
    input  logic       rel_l,
    input  logic       req_r,
    input  logic       rel_r,
    output tok_owner_t owner,
    output logic       pend_l,
    output logic       pend_r
);
    tok_owner_t owner_nx;
    logic       pend_l_nx;
    logic       pend_r_nx;

    // Next-state rules for grant, defer, hand-over and withdraw.
    always_comb begin
        owner_nx  = owner;
        pend_l_nx = pend_l;
        pend_r_nx = pend_r;
        case (owner)
            TOK_FREE: begin
                pend_l_nx = 1'b0;
                pend_r_nx = 1'b0;
                if (req_l) begin
                    owner_nx  = TOK_LEFT;
                    pend_r_nx = req_r;
                end else if (req_r) begin
                    owner_nx  = TOK_RIGHT;
                end
            end
            TOK_LEFT: begin
                pend_l_nx = 1'b0;
                if (rel_l) begin
                    owner_nx  = ((pend_r | req_r) & ~rel_r) ? TOK_RIGHT : TOK_FREE;
                    pend_r_nx = 1'b0;
                end else if (req_r) begin
                    pend_r_nx = 1'b1;
                end else if (rel_r) begin
                    pend_r_nx = 1'b0;
                end
            end
            TOK_RIGHT: begin
                pend_r_nx = 1'b0;
                if (rel_r) begin
                    owner_nx  = ((pend_l | req_l) & ~rel_l) ? TOK_LEFT : TOK_FREE;
                    pend_l_nx = 1'b0;
                end else if (req_l) begin
                    pend_l_nx = 1'b1;
                end else if (rel_l) begin
                    pend_l_nx = 1'b0;
                end
            end
            default: begin
                owner_nx  = TOK_FREE;
                pend_l_nx = 1'b0;
                pend_r_nx = 1'b0;
            end
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner  <= TOK_FREE;
            pend_l <= 1'b0;
            pend_r <= 1'b0;
        end else begin
            owner  <= owner_nx;
            pend_l <= pend_l_nx;
            pend_r <= pend_r_nx;
        end
    end

    // R3: a lone left request on a free token grants it to the left.
    p_grant_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == TOK_FREE && req_l) |=> owner == TOK_LEFT);

    // R4: on a tie the left wins and the right request stays pending.
    p_tie_left_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == TOK_FREE && req_l && req_r) |=> (owner == TOK_LEFT && pend_r));

    // R5: the non-owner cannot take a held token.
    p_no_steal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == TOK_LEFT && !rel_l) |=> owner == TOK_LEFT);

    // R7: a release with a pending right request hands the token over.
    p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == TOK_LEFT && rel_l && pend_r && !rel_r) |=> owner == TOK_RIGHT);

    // R2: a free token never carries a pending request; the owner never has one.
    p_pend_consistent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(owner == TOK_FREE && (pend_l || pend_r)) &&
        !(owner == TOK_LEFT && pend_l) && !(owner == TOK_RIGHT && pend_r));
endmodule

// File: rtl/sem_dual_token.sv
// Dual-port hardware semaphore unit (top).
// Holds NUM_FLAGS two-sided tokens shared by a left and a right port.
// A port writes 0 to request, 1 to release, and reads 0 when it owns the
// selected token. Assumes a single clock and synchronous active-low reset.
module sem_dual_token
    import sem_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int NUM_FLAGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_sel,
    input  logic              l_mem_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wbit,
    output logic              l_rbit,
    input  logic              r_sem_sel,
    input  logic              r_mem_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wbit,
    output logic              r_rbit
);
    localparam int SLOT_W = $clog2(NUM_FLAGS);

    logic                 l_acc, r_acc;
    logic [SLOT_W-1:0]    l_slot, r_slot;
    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    tok_owner_t           tok_own [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] tok_pl, tok_pr;

    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_l (
        .clk(clk), .rst_n(rst_n), .sem_sel(l_sem_sel), .mem_en(l_mem_en),
        .wr(l_wr), .addr(l_addr), .wbit(l_wbit),
        .acc(l_acc), .slot(l_slot), .req(l_req), .rel(l_rel)
    );

    sem_port_decode #(.ADDR_W(ADDR_W), .NUM_FLAGS(NUM_FLAGS)) u_dec_r (
        .clk(clk), .rst_n(rst_n), .sem_sel(r_sem_sel), .mem_en(r_mem_en),
        .wr(r_wr), .addr(r_addr), .wbit(r_wbit),
        .acc(r_acc), .slot(r_slot), .req(r_req), .rel(r_rel)
    );

    // One token state machine per slot.
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_tok
        sem_flag u_flag (
            .clk(clk), .rst_n(rst_n),
            .req_l(l_req[g]), .rel_l(l_rel[g]),
            .req_r(r_req[g]), .rel_r(r_rel[g]),
            .owner(tok_own[g]), .pend_l(tok_pl[g]), .pend_r(tok_pr[g])
        );
    end

    // Per-port read view: 0 only when this port owns the addressed token.
    always_comb begin
        l_rbit = 1'b1;
        r_rbit = 1'b1;
        if (l_acc) l_rbit = (tok_own[l_slot] != TOK_LEFT);
        if (r_acc) r_rbit = (tok_own[r_slot] != TOK_RIGHT);
    end

    // R4: both ports never see ownership of the same token at once.
    p_mutual_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && r_acc && l_slot == r_slot) |-> (l_rbit || r_rbit));
endmodule

// File: tb/tb_sem_dual_token.sv
// Directed bench for the dual-port semaphore unit.
module tb_sem_dual_token;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sem_sel = 0, l_mem_en = 0, l_wr = 0, l_wbit = 1;
    logic        r_sem_sel = 0, r_mem_en = 0, r_wr = 0, r_wbit = 1;
    logic [14:0] l_addr = '0, r_addr = '0;
    logic        l_rbit, r_rbit;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;   // 50 MHz

    sem_dual_token dut (
        .clk(clk), .rst_n(rst_n),
        .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr),
        .l_addr(l_addr), .l_wbit(l_wbit), .l_rbit(l_rbit),
        .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr),
        .r_addr(r_addr), .r_wbit(r_wbit), .r_rbit(r_rbit)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(int p, logic sel, logic men, logic wr, logic [14:0] a, logic d);
        if (p == 0) begin
            l_sem_sel = sel; l_mem_en = men; l_wr = wr; l_addr = a; l_wbit = d;
        end else begin
            r_sem_sel = sel; r_mem_en = men; r_wr = wr; r_addr = a; r_wbit = d;
        end
    endtask

    // One write from one port, taking effect at the next rising edge.
    task automatic wr1(int p, logic [14:0] a, logic d, logic men);
        @(negedge clk);
        drive(p, 1'b1, men, 1'b1, a, d);
        @(negedge clk);
        drive(p, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    endtask

    // Writes from both ports in the same cycle.
    task automatic wr2(logic [14:0] al, logic dl, logic [14:0] ar, logic dr);
        @(negedge clk);
        drive(0, 1'b1, 1'b0, 1'b1, al, dl);
        drive(1, 1'b1, 1'b0, 1'b1, ar, dr);
        @(negedge clk);
        drive(0, 1'b0, 1'b0, 1'b0, '0, 1'b1);
        drive(1, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    endtask

    // Read the bit one port sees, sampled in the low phase.
    task automatic rd(int p, logic [14:0] a, logic men, output logic v);
        @(negedge clk);
        drive(p, 1'b1, men, 1'b0, a, 1'b1);
        #2;
        v = (p == 0) ? l_rbit : r_rbit;
        drive(p, 1'b0, 1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_reset;
        logic v;
        for (int i = 0; i < 8; i++) begin
            rd(0, 15'(i), 1'b0, v); chk("R2 left reset read", v, 1'b1);
            rd(1, 15'(i), 1'b0, v); chk("R2 right reset read", v, 1'b1);
        end
    endtask

    task automatic t_basic;
        logic v;
        wr1(0, 15'd2, 1'b0, 1'b0);
        rd(0, 15'd2, 1'b0, v); chk("R3 owner reads 0", v, 1'b0);
        rd(1, 15'd2, 1'b0, v); chk("R3 other reads 1", v, 1'b1);
        wr1(0, 15'd2, 1'b1, 1'b0);
        rd(0, 15'd2, 1'b0, v); chk("R6 freed left", v, 1'b1);
        rd(1, 15'd2, 1'b0, v); chk("R6 freed right", v, 1'b1);
        wr1(1, 15'd2, 1'b0, 1'b0);
        rd(1, 15'd2, 1'b0, v); chk("R3 right owner reads 0", v, 1'b0);
        wr1(1, 15'd2, 1'b1, 1'b0);
        rd(0, 15'd2, 1'b0, v); chk("R6 right release frees", v, 1'b1);
    endtask

    task automatic t_mem_block;
        logic v;
        wr1(0, 15'd3, 1'b0, 1'b1);
        rd(0, 15'd3, 1'b0, v); chk("R1 blocked write ignored left", v, 1'b1);
        wr1(1, 15'd3, 1'b0, 1'b0);
        rd(1, 15'd3, 1'b0, v); chk("R1 right took token after blocked write", v, 1'b0);
        rd(1, 15'd3, 1'b1, v); chk("R1 read with memory enable is 1", v, 1'b1);
        wr1(1, 15'd3, 1'b1, 1'b1);
        rd(1, 15'd3, 1'b0, v); chk("R1 blocked release ignored", v, 1'b0);
        wr1(1, 15'd3, 1'b1, 1'b0);
        rd(0, 15'd3, 1'b0, v); chk("R1 cleanup free", v, 1'b1);
    endtask

    task automatic t_tie;
        logic v;
        wr2(15'd4, 1'b0, 15'd4, 1'b0);
        rd(0, 15'd4, 1'b0, v); chk("R4 left wins tie", v, 1'b0);
        rd(1, 15'd4, 1'b0, v); chk("R4 right loses tie", v, 1'b1);
        wr1(0, 15'd4, 1'b1, 1'b0);
        rd(1, 15'd4, 1'b0, v); chk("R4 right pending then owns", v, 1'b0);
        rd(0, 15'd4, 1'b0, v); chk("R7 left lost after handover", v, 1'b1);
        wr1(1, 15'd4, 1'b1, 1'b0);
        rd(0, 15'd4, 1'b0, v); chk("R6 tie token freed", v, 1'b1);
    endtask

    task automatic t_defer;
        logic v;
        wr1(1, 15'd5, 1'b0, 1'b0);
        wr1(0, 15'd5, 1'b0, 1'b0);
        rd(1, 15'd5, 1'b0, v); chk("R5 owner keeps token", v, 1'b0);
        rd(0, 15'd5, 1'b0, v); chk("R5 requester still reads 1", v, 1'b1);
        wr1(1, 15'd5, 1'b0, 1'b0);
        rd(1, 15'd5, 1'b0, v); chk("R10 owner rewrite keeps token", v, 1'b0);
        wr1(1, 15'd5, 1'b1, 1'b0);
        rd(0, 15'd5, 1'b0, v); chk("R7 pending left now owns", v, 1'b0);
        rd(1, 15'd5, 1'b0, v); chk("R7 right released", v, 1'b1);
        wr1(0, 15'd5, 1'b1, 1'b0);
        rd(1, 15'd5, 1'b0, v); chk("R6 defer token freed", v, 1'b1);
    endtask

    task automatic t_withdraw;
        logic v;
        wr1(0, 15'd6, 1'b0, 1'b0);
        wr1(1, 15'd6, 1'b0, 1'b0);
        wr1(1, 15'd6, 1'b1, 1'b0);
        rd(0, 15'd6, 1'b0, v); chk("R8 owner unaffected by withdraw", v, 1'b0);
        wr1(0, 15'd6, 1'b1, 1'b0);
        rd(1, 15'd6, 1'b0, v); chk("R8 withdrawn right not granted", v, 1'b1);
        rd(0, 15'd6, 1'b0, v); chk("R8 token free", v, 1'b1);
    endtask

    task automatic t_same_cycle_handover;
        logic v;
        wr1(0, 15'd0, 1'b0, 1'b0);
        wr2(15'd0, 1'b1, 15'd0, 1'b0);
        rd(1, 15'd0, 1'b0, v); chk("R7 same-cycle handover right owns", v, 1'b0);
        rd(0, 15'd0, 1'b0, v); chk("R7 same-cycle handover left out", v, 1'b1);
        wr1(1, 15'd0, 1'b1, 1'b0);
        rd(1, 15'd0, 1'b0, v); chk("R6 token 0 freed", v, 1'b1);
    endtask

    task automatic t_index;
        logic v;
        wr1(0, 15'h7FF9, 1'b0, 1'b0);
        rd(0, 15'h0001, 1'b0, v); chk("R9 upper bits ignored", v, 1'b0);
        wr1(1, 15'h0007, 1'b0, 1'b0);
        rd(1, 15'h0001, 1'b0, v); chk("R9 right sees 1 on slot 1", v, 1'b1);
        rd(0, 15'h0007, 1'b0, v); chk("R9 left sees 1 on slot 7", v, 1'b1);
        rd(1, 15'h0407, 1'b0, v); chk("R9 right owns slot 7", v, 1'b0);
        rd(0, 15'h0002, 1'b0, v); chk("R9 neighbour slot free", v, 1'b1);
        wr1(0, 15'h1231, 1'b1, 1'b0);
        wr1(1, 15'h4AAF, 1'b1, 1'b0);
        rd(1, 15'h0001, 1'b0, v); chk("R9 slot 1 freed", v, 1'b1);
        rd(0, 15'h0007, 1'b0, v); chk("R9 slot 7 freed", v, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_mem_block();
        t_tie();
        t_defer();
        t_withdraw();
        t_same_cycle_handover();
        t_index();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule